// File: doc/BRIEF.md
# Predicated SIMD Lane Execution Stage

This block is one execution stage of a small SIMD datapath. Each accepted instruction brings two vector operands, the prior contents of the destination vector, an opcode and the index of a predicate mask. Every lane of the vector works on its own element. A lane whose mask bit is set may change its element. A lane whose bit is clear passes the prior destination value through unchanged. The block returns the resulting vector and a per-lane write-enable vector, one cycle later. The vector register storage sits outside the block.

Compare instructions produce one condition bit per lane and write those bits into one of a small set of mask registers. Later instructions select that mask register and so run only on the lanes whose compare held. Mask register 0 always reads as all ones, so an instruction that selects it runs on every lane. All lanes are computed in the same cycle, whatever the mask holds. Input and output are valid/ready streams with a single output register. The input is ready whenever that register is empty or is being drained in the same cycle. While the output is stalled, the result held in the register does not change.

Top module: `vmx_exec`

## Requirements
- R1: After reset the output is not valid, the input is ready, and mask registers 1 to 3 hold all zeros.
- R2: Opcode 0 (add) and opcode 1 (subtract, a minus b) compute each enabled lane modulo 2^EW. Lane i occupies bits [i*EW +: EW] of every vector, and mask bit i belongs to lane i.
- R3: Opcode 2 (masked move) writes operand a into every enabled lane.
- R4: A lane whose applied mask bit is 0 returns its prior destination element, and its write-enable bit is 0.
- R5: Opcodes 3 (equal), 4 (signed less-than, a < b) and 5 (unsigned less-than, a < b) give the lane bit 1 when true. These bits go into mask register in_mdst for the enabled lanes only. Disabled lanes keep their previous mask bit. A compare writes no destination lane: write-enable is all zero and the data equals the prior destination.
- R6: Mask register 0 reads as all ones, and a compare that targets it changes nothing.
- R7: The result appears on the output, with out_valid, in the cycle after the input is accepted. For opcodes 0 to 2, out_wen equals the applied mask.
- R8: A mask written by a compare gates an instruction accepted on the very next cycle.
- R9: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_data and out_wen hold.
- R10: Opcodes 6 and 7 write no lane and no mask register. The data returned equals the prior destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Stage can accept an instruction |
| in_op | input | 3 | Opcode |
| in_msel | input | 2 | Index of the mask register that gates the lanes |
| in_mdst | input | 2 | Mask register written by a compare |
| in_a | input | LANES*EW | Operand vector a |
| in_b | input | LANES*EW | Operand vector b |
| in_old | input | LANES*EW | Prior destination vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | LANES*EW | Result vector |
| out_wen | output | LANES | Per-lane write enable |

## Verification
Two things can fall in the same cycle. One is a compare updating a mask register. The other is the read of that same register by the next instruction, which is accepted on the following edge. The bench issues a compare, then an instruction that selects the compare's target mask with no idle cycle between them. Its scoreboard predicts the lane results from its own mask model, which it updates at the moment of acceptance. A second overlap is a new instruction arriving while the output is held by back-pressure. The bench forces out_ready low and confirms that in_ready drops. After the stall is released, it checks that the held result and the later one come out in order.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MOV  = 3'd2,
    OP_CEQ  = 3'd3,
    OP_CLTS = 3'd4,
    OP_CLTU = 3'd5,
    OP_RS6  = 3'd6,
    OP_RS7  = 3'd7
  } vop_e;

  function automatic logic op_is_cmp(input vop_e op);
    return (op == OP_CEQ) || (op == OP_CLTS) || (op == OP_CLTU);
  endfunction

endpackage

// File: rtl/vmx_lane.sv
module vmx_lane
  import vmx_pkg::*;
#(
  parameter int EW = 16
) (
  input  vop_e          op,
  input  logic          en,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [EW-1:0] old,
  output logic [EW-1:0] res,
  output logic          wr,
  output logic          cond
);

  always_comb begin
    res  = old;
    wr   = 1'b0;
    cond = 1'b0;
    case (op)
      OP_ADD: if (en) begin
        res = a + b;
        wr  = 1'b1;
      end
      OP_SUB: if (en) begin
        res = a - b;
        wr  = 1'b1;
      end
      OP_MOV: if (en) begin
        res = a;
        wr  = 1'b1;
      end
      OP_CEQ:  cond = (a == b);
      OP_CLTS: cond = ($signed(a) < $signed(b));
      OP_CLTU: cond = (a < b);
      default: ;
    endcase
  end

endmodule

// File: rtl/vmx_mask_file.sv
module vmx_mask_file #(
  parameter int LANES = 8,
  parameter int NREG  = 4,
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    rd_idx,
  output logic [LANES-1:0] rd_mask,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [LANES-1:0] wr_sel,
  input  logic [LANES-1:0] wr_bits
);

  // slot 0 is the constant all-ones mask and has no storage
  logic [LANES-1:0] stor [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) stor[k] <= '0;
    end else if (wr_en) begin
      for (int k = 1; k < NREG; k++) begin
        if (wr_idx == IW'(k))
          stor[k] <= (stor[k] & ~wr_sel) | (wr_bits & wr_sel);
      end
    end
  end

  always_comb begin
    if (rd_idx == '0) rd_mask = '1;
    else              rd_mask = stor[rd_idx];
  end

endmodule

// File: rtl/vmx_exec.sv
module vmx_exec
  import vmx_pkg::*;
#(
  parameter int LANES = 8,
  parameter int EW    = 16,
  parameter int NMASK = 4,
  localparam int VW   = LANES * EW,
  localparam int MIW  = (NMASK > 1) ? $clog2(NMASK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [MIW-1:0]   in_msel,
  input  logic [MIW-1:0]   in_mdst,
  input  logic [VW-1:0]    in_a,
  input  logic [VW-1:0]    in_b,
  input  logic [VW-1:0]    in_old,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VW-1:0]    out_data,
  output logic [LANES-1:0] out_wen
);

  vop_e             op_e;
  logic             accept;
  logic [LANES-1:0] act_mask;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_cond;
  logic [VW-1:0]    lane_res;

  assign op_e     = vop_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vmx_mask_file #(.LANES(LANES), .NREG(NMASK)) u_masks (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (in_msel),
    .rd_mask (act_mask),
    .wr_en   (accept && op_is_cmp(op_e)),
    .wr_idx  (in_mdst),
    .wr_sel  (act_mask),
    .wr_bits (lane_cond)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vmx_lane #(.EW(EW)) u_lane (
      .op   (op_e),
      .en   (act_mask[g]),
      .a    (in_a[g*EW +: EW]),
      .b    (in_b[g*EW +: EW]),
      .old  (in_old[g*EW +: EW]),
      .res  (lane_res[g*EW +: EW]),
      .wr   (lane_wr[g]),
      .cond (lane_cond[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_wen   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= lane_res;
      out_wen   <= lane_wr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vmx_exec_chk.sv
module vmx_exec_chk #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  parameter int NMASK = 4,
  localparam int VW   = LANES * EW,
  localparam int MIW  = (NMASK > 1) ? $clog2(NMASK) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [MIW-1:0]   in_msel,
  input logic [VW-1:0]    in_old,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VW-1:0]    out_data,
  input logic [LANES-1:0] out_wen
);

  // R7
  valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  stall_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_wen)));

  // R5
  no_lane_write_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op >= 3'd3) |=> (out_wen == '0));

  // R6
  mask_zero_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op < 3'd3 && in_msel == '0) |=> (out_wen == '1));

  for (genvar g = 0; g < LANES; g++) begin : g_hold
    // R4
    masked_lane_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=>
        (out_wen[g] || (out_data[g*EW +: EW] == $past(in_old[g*EW +: EW]))));
  end

endmodule

bind vmx_exec vmx_exec_chk #(.LANES(LANES), .EW(EW), .NMASK(NMASK)) u_chk (.*);

// File: tb/test_vmx_exec.sv
module test_vmx_exec;

  localparam int LANES = 8;
  localparam int EW    = 16;
  localparam int VW    = LANES * EW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2:0]       in_op = '0;
  logic [1:0]       in_msel = '0;
  logic [1:0]       in_mdst = '0;
  logic [VW-1:0]    in_a = '0, in_b = '0, in_old = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VW-1:0]    out_data;
  logic [LANES-1:0] out_wen;

  vmx_exec #(.LANES(LANES), .EW(EW), .NMASK(4)) i_vmx_exec (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int rdy_mode = 0; // 0 always ready, 1 stalled, 2 random

  logic [LANES-1:0] bm [4];
  logic [VW-1:0]    q_data [$];
  logic [LANES-1:0] q_wen  [$];
  string            q_tag  [$];

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, applied at acceptance
  task automatic predict(input logic [2:0] op, input logic [1:0] ms, input logic [1:0] md,
                         input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] old,
                         input string tag);
    logic [LANES-1:0] m, c, w;
    logic [VW-1:0]    d;
    m = (ms == 2'd0) ? '1 : bm[ms];
    d = old; w = '0; c = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [EW-1:0] ea, eb;
      ea = a[i*EW +: EW]; eb = b[i*EW +: EW];
      case (op)
        3'd0: if (m[i]) begin d[i*EW +: EW] = ea + eb; w[i] = 1'b1; end
        3'd1: if (m[i]) begin d[i*EW +: EW] = ea - eb; w[i] = 1'b1; end
        3'd2: if (m[i]) begin d[i*EW +: EW] = ea;      w[i] = 1'b1; end
        3'd3: c[i] = (ea == eb);
        3'd4: c[i] = ($signed(ea) < $signed(eb));
        3'd5: c[i] = (ea < eb);
        default: ;
      endcase
    end
    if (op >= 3'd3 && op <= 3'd5 && md != 2'd0)
      bm[md] = (bm[md] & ~m) | (c & m);
    q_data.push_back(d);
    q_wen.push_back(w);
    q_tag.push_back(tag);
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic issue(input logic [2:0] op, input logic [1:0] ms, input logic [1:0] md,
                       input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] old,
                       input string tag);
    bit ok;
    in_valid = 1'b1; in_op = op; in_msel = ms; in_mdst = md;
    in_a = a; in_b = b; in_old = old;
    forever begin
      #1 ok = in_ready;
      if (ok) predict(op, ms, md, a, b, old, tag);
      @(negedge clk);
      if (ok) break;
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [VW-1:0] splat(input logic [EW-1:0] v);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*EW +: EW] = v;
    return r;
  endfunction

  function automatic logic [VW-1:0] ramp(input logic [EW-1:0] base, input logic [EW-1:0] step);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*EW +: EW] = base + EW'(i) * step;
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] r;
    for (int i = 0; i < VW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // out_ready driver
  initial forever begin
    @(negedge clk);
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = $urandom_range(0, 3) != 0;
    endcase
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R7 unexpected result", out_data, '0);
      end else begin
        logic [VW-1:0]    ed;
        logic [LANES-1:0] ew;
        string            t;
        ed = q_data.pop_front(); ew = q_wen.pop_front(); t = q_tag.pop_front();
        check(out_data == ed, {t, " data"}, out_data, ed);
        check(out_wen == ew, {t, " wen"}, VW'(out_wen), VW'(ew));
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) bm[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", VW'(out_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready after reset", VW'(in_ready), VW'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 add/sub through the all-ones mask (R6)
    issue(3'd0, 2'd0, 2'd0, ramp(16'd1, 16'd3), ramp(16'd100, 16'd7), splat(16'h5555), "R2 add");
    issue(3'd1, 2'd0, 2'd0, splat(16'h0002), ramp(16'h0000, 16'h0001), splat(16'h1111), "R2 sub wrap");
    issue(3'd0, 2'd0, 2'd0, splat(16'hFFFF), splat(16'h0003), '0, "R2 add wrap R6");
    // R1 mask 1 is all zeros: nothing written (R4)
    issue(3'd0, 2'd1, 2'd0, splat(16'h0001), splat(16'h0001), ramp(16'h0A00, 16'h0011), "R1 R4 zero mask");
    idle(2);

    // R5 equal into mask 1, R8 used on the very next cycle by a move (R3)
    issue(3'd3, 2'd0, 2'd1, ramp(16'd0, 16'd1), {splat(16'd0)} | ramp(16'd0, 16'd1) & {{(VW/2){1'b0}}, {(VW/2){1'b1}}}, splat(16'hBEEF), "R5 cmp eq");
    issue(3'd2, 2'd1, 2'd0, splat(16'h7777), '0, splat(16'h0101), "R8 R3 move next cycle");
    // R5 signed less-than into mask 2, then subtract under it (R8)
    issue(3'd4, 2'd0, 2'd2, ramp(16'hFFFC, 16'd1), splat(16'd0), splat(16'h0F0F), "R5 cmp lt signed");
    issue(3'd1, 2'd2, 2'd0, splat(16'd50), ramp(16'd1, 16'd1), splat(16'h2222), "R8 R4 sub masked");
    // R5 unsigned less-than under mask 2 into mask 3: disabled lanes keep old bits
    issue(3'd5, 2'd2, 2'd3, ramp(16'hFFFC, 16'd1), splat(16'd3), splat(16'h3333), "R5 cmp lt unsigned");
    issue(3'd0, 2'd3, 2'd0, splat(16'd9), splat(16'd1), splat(16'h4444), "R8 add under merged mask");
    // R6 compare into mask 0 is ignored
    issue(3'd3, 2'd0, 2'd0, splat(16'd1), splat(16'd2), splat(16'h5555), "R6 cmp to mask0");
    issue(3'd0, 2'd0, 2'd0, splat(16'd4), splat(16'd4), '0, "R6 mask0 still full");
    // R10 reserved opcodes write nothing and leave masks alone
    issue(3'd6, 2'd0, 2'd1, splat(16'd1), splat(16'd1), splat(16'h6666), "R10 op6");
    issue(3'd7, 2'd0, 2'd2, splat(16'd1), splat(16'd1), splat(16'h7777), "R10 op7");
    issue(3'd2, 2'd1, 2'd0, splat(16'hABCD), '0, splat(16'h0808), "R10 mask1 unchanged");
    idle(2);

    // R9 back-pressure
    rdy_mode = 1;
    @(negedge clk);
    issue(3'd0, 2'd0, 2'd0, splat(16'd10), splat(16'd20), '0, "R9 held result");
    in_valid = 1'b1; in_op = 3'd1; in_msel = 2'd0;
    in_a = splat(16'd9); in_b = splat(16'd4); in_old = '0;
    repeat (3) begin
      #1 check(in_ready == 1'b0, "R9 stalled input", VW'(in_ready), '0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    rdy_mode = 0;
    @(negedge clk);
    issue(3'd1, 2'd0, 2'd0, splat(16'd9), splat(16'd4), '0, "R9 after release");
    idle(2);

    // random mix with random back-pressure (R2 R3 R4 R5 R8)
    rdy_mode = 2;
    for (int n = 0; n < 60; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      issue(op, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), rnd(), rnd(), rnd(), "R2 R5 random");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    in_valid = 1'b0;
    rdy_mode = 0;
    for (int w = 0; w < 50 && q_data.size() != 0; w++) @(negedge clk);
    check(q_data.size() == 0, "R7 all results delivered", VW'(q_data.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule